// File: doc/BRIEF.md
# Quad I/O Serial Flash Read Controller

This block fetches 32-bit words from a serial NOR flash with the quad I/O fast-read command. A host hands it a 24-bit byte address over a request handshake. The block runs one framed transaction on the flash pins and returns the assembled word on a one-cycle response strobe. The flash clock is a programmable division of the system clock. The four data lanes are exposed as separate output, output-enable and input vectors, and the pad ring joins them.

The byte sent in the mode slot after the address comes from a dedicated input, `mode_byte`. It never comes from leftover address bits. The block keeps a flag that mirrors whether the flash is in continuous-read mode. A mode byte whose upper nibble is 0xA sets the flag, and the next transaction then leaves out the opcode. A one-cycle `exit_req` pulse makes the next transaction send 0xFF in the mode slot. That takes the flash, and the flag, out of continuous-read mode.

Handshake rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole time `busy` is high, so a request offered then is ignored and holds no state. The response has no back-pressure: `rsp_valid` is high for exactly one cycle, and `rsp_data` holds its value until the next response.

Top module: `qspi_quad_reader`

## Requirements
- R1: When continuous mode is off, a transaction starts by sending opcode 0xEB on lane 0 only (`io_oe` = 4'b0001), most significant bit first, one bit per SCLK cycle.
- R2: The address follows in 6 SCLK cycles, one nibble per cycle, most significant nibble first. The mode byte then follows in 2 cycles, upper nibble first. Both phases drive all four lanes (`io_oe` = 4'hF), with lane 3 carrying the nibble's bit 3.
- R3: The mode byte sent is the value of `mode_byte` at request acceptance. It does not depend on the address.
- R4: After the mode byte come exactly 4 dummy cycles and then 8 data cycles. `io_oe` is 4'h0 in all of them.
- R5: The data nibbles are sampled on rising SCLK edges. Nibble k (k = 0..7) is the upper nibble of byte k/2 when k is even and the lower nibble when k is odd. Bytes are at increasing addresses from the request address, wrapping at 24 bits, and `rsp_data[8*j+7:8*j]` holds the byte at address + j.
- R6: `cont_mode` goes high after a transaction sends a mode byte with upper nibble 0xA, and low after one with any other upper nibble. While it is high, the next transaction leaves out the opcode: 20 SCLK cycles instead of 28.
- R7: After an `exit_req` pulse, the next accepted transaction sends mode byte 0xFF whatever `mode_byte` holds, which clears `cont_mode`.
- R8: The SCLK period is 2*(`clk_div`+1) system clocks. SCLK idles low (SPI mode 0): lanes change on falling edges and are sampled on rising edges.
- R9: `cs_n` is low for the whole transaction. It is high for at least one SCLK period between transactions, and SCLK stays low and all lanes stay released while it is high.
- R10: `busy` goes high on acceptance and falls in the cycle `rsp_valid` pulses. Requests offered while busy are ignored.
- R11: After reset `cs_n` = 1, `sclk` = 0, `io_oe` = 0, `busy` = 0, `req_ready` = 1, `rsp_valid` = 0 and `cont_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | SCLK half-period in system clocks, minus one; change only while idle |
| mode_byte | input | 8 | Byte sent in the mode slot |
| exit_req | input | 1 | Pulse: force mode byte 0xFF on the next transaction |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 24 | Byte address of the word |
| rsp_valid | output | 1 | One-cycle strobe: rsp_data is new |
| rsp_data | output | 32 | Read word, lowest address in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| cont_mode | output | 1 | Flash is assumed in continuous-read mode |
| sclk | output | 1 | Flash serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 32-bit word, 4 dummy cycles and an 8-bit divider. At run time it sets `clk_div` to 0, 1 and 3, which brings the fastest SCLK, the CS gap in back-to-back reads and the divider count within reach. A behavioural flash on the pins keeps its own continuous-mode state. That lets the bench check opcode omission, the mode byte sent with an address that holds 0xA nibbles, the exit sequence and a word read across a 64 KiB boundary.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_GAP
  } phase_t;

  localparam logic [7:0] READ_OPCODE = 8'hEB;
  localparam logic [7:0] EXIT_MODE   = 8'hFF;
  localparam logic [3:0] CONT_NIBBLE = 4'hA;
endpackage

// File: rtl/qrd_sclk_div.sv
module qrd_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/qrd_seq.sv
module qrd_seq
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int DUMMY_CYC = 4,
  localparam int ADDR_NIB = ADDR_W / 4,
  localparam int DATA_NIB = DATA_W / 4,
  localparam int CNT_W    = $clog2(8 + ADDR_NIB + 2 + DUMMY_CYC + DATA_NIB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mode,
  input  logic              tick,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              active,
  output logic              sample_en,
  output logic [CNT_W-1:0]  nib_idx,
  output logic              mode_done,
  output logic [3:0]        mode_hi,
  output logic              done
);
  phase_t              phase_q, phase_nx;
  logic [CNT_W-1:0]    cnt_q, last_cnt;
  logic                sclk_q, cs_n_q, done_q;
  logic [ADDR_W-1:0]   addr_q, addr_sh;
  logic [7:0]          mode_q;
  logic [2:0]          cmd_bit;

  always_comb begin
    last_cnt = '0;
    phase_nx = PH_IDLE;
    unique case (phase_q)
      PH_CMD:   begin last_cnt = CNT_W'(7);            phase_nx = PH_ADDR;  end
      PH_ADDR:  begin last_cnt = CNT_W'(ADDR_NIB - 1); phase_nx = PH_MODE;  end
      PH_MODE:  begin last_cnt = CNT_W'(1);            phase_nx = PH_DUMMY; end
      PH_DUMMY: begin last_cnt = CNT_W'(DUMMY_CYC - 1);phase_nx = PH_DATA;  end
      PH_DATA:  begin last_cnt = CNT_W'(DATA_NIB - 1); phase_nx = PH_GAP;   end
      default:  begin last_cnt = CNT_W'(1);            phase_nx = PH_IDLE;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      addr_q  <= '0;
      mode_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start) begin
          addr_q  <= addr;
          mode_q  <= mode;
          cnt_q   <= '0;
          sclk_q  <= 1'b0;
          cs_n_q  <= 1'b0;
          phase_q <= skip_cmd ? PH_ADDR : PH_CMD;
        end
      end else if (tick) begin
        if (phase_q == PH_GAP) begin
          if (cnt_q == last_cnt) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (cnt_q == last_cnt) begin
            cnt_q   <= '0;
            phase_q <= phase_nx;
            if (phase_q == PH_DATA) cs_n_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign cmd_bit = 3'd7 - cnt_q[2:0];
  assign addr_sh = addr_q << (4 * cnt_q);

  always_comb begin
    io_out = 4'h0;
    io_oe  = 4'h0;
    unique case (phase_q)
      PH_CMD:  begin io_oe = 4'b0001; io_out = {3'b000, READ_OPCODE[cmd_bit]}; end
      PH_ADDR: begin io_oe = 4'hF;    io_out = addr_sh[ADDR_W-1 -: 4];         end
      PH_MODE: begin io_oe = 4'hF;    io_out = (cnt_q == '0) ? mode_q[7:4] : mode_q[3:0]; end
      default: begin io_oe = 4'h0;    io_out = 4'h0;                           end
    endcase
  end

  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign active    = (phase_q != PH_IDLE);
  assign done      = done_q;
  assign sample_en = tick && !sclk_q && (phase_q == PH_DATA);
  assign nib_idx   = cnt_q;
  assign mode_done = tick && sclk_q && (phase_q == PH_MODE) && (cnt_q == last_cnt);
  assign mode_hi   = mode_q[7:4];

  // R9
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> (!sclk_q && io_oe == 4'h0));

  // R8
  sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk_q));

  // R4
  lane_enable_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'b0001) || (io_oe == 4'hF));
endmodule

// File: rtl/qrd_rx.sv
module qrd_rx #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  localparam int DATA_NIB = DATA_W / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [CNT_W-1:0]  nib_idx,
  input  logic [3:0]        lanes,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (sample_en) begin
      for (int i = 0; i < DATA_NIB; i++) begin
        if (nib_idx == CNT_W'(i))
          data_q[8*(i/2) + ((i % 2 == 0) ? 4 : 0) +: 4] <= lanes;
      end
    end
  end

  assign data = data_q;
endmodule

// File: rtl/qspi_quad_reader.sv
module qspi_quad_reader
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int DUMMY_CYC = 4,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [7:0]        mode_byte,
  input  logic              exit_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              cont_mode,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int CNT_W = $clog2(8 + ADDR_W/4 + 2 + DUMMY_CYC + DATA_W/4);

  logic             tick, active, start, sample_en, mode_done, done;
  logic [CNT_W-1:0] nib_idx;
  logic [3:0]       mode_hi;
  logic             exit_pend_q, cont_q;
  logic [7:0]       mode_sel;

  assign req_ready = !active;
  assign busy      = active;
  assign start     = req_valid && req_ready;
  assign mode_sel  = exit_pend_q ? EXIT_MODE : mode_byte;

  qrd_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .div(clk_div), .tick(tick)
  );

  qrd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUMMY_CYC(DUMMY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_cmd(cont_q),
    .addr(req_addr), .mode(mode_sel), .tick(tick),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
    .active(active), .sample_en(sample_en), .nib_idx(nib_idx),
    .mode_done(mode_done), .mode_hi(mode_hi), .done(done)
  );

  qrd_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .nib_idx(nib_idx),
    .lanes(io_in), .data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_pend_q <= 1'b0;
      cont_q      <= 1'b0;
    end else begin
      if (start)     exit_pend_q <= 1'b0;
      if (exit_req)  exit_pend_q <= 1'b1;
      if (mode_done) cont_q <= (mode_hi == CONT_NIBBLE);
    end
  end

  assign cont_mode = cont_q;
  assign rsp_valid = done;

  // R6
  cont_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_q) |-> $past(mode_done && mode_hi == CONT_NIBBLE));

  // R10
  busy_ends_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_qspi_quad_reader.sv
`timescale 1ns/1ps
module tb_qspi_quad_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic [7:0]  mode_byte = 8'hFF;
  logic        exit_req = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        busy, cont_mode, sclk, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = 4'h0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qspi_quad_reader dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .mode_byte(mode_byte),
    .exit_req(exit_req), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .cont_mode(cont_mode), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] a);
    return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
  endfunction

  // ---------------- behavioural flash ----------------
  bit          m_cont = 0, m_expect_cmd = 0;
  int          cyc = 0, base = 0, m_txn = 0, m_oe_err = 0, m_last_cycles = 0;
  logic [7:0]  m_cmd = '0, m_mode = '0, m_last_cmd = '0, m_last_mode = '0;
  logic [23:0] m_addr = '0;
  realtime     t_rise_prev = 0, t_rise_last = 0, t_cs_rise = 0, m_gap = 0;

  always @(negedge cs_n) begin
    m_gap = $realtime - t_cs_rise;
    cyc = 0;
    m_expect_cmd = !m_cont;
    base = m_expect_cmd ? 8 : 0;
    m_cmd = '0; m_mode = '0; m_addr = '0;
  end

  always @(posedge sclk) begin
    int a;
    if (!cs_n) begin
      t_rise_prev = t_rise_last;
      t_rise_last = $realtime;
      if (cyc < base) begin
        m_cmd = {m_cmd[6:0], io_out[0]};
        if (io_oe != 4'b0001) m_oe_err++;
      end else begin
        a = cyc - base;
        if (a < 6) begin
          m_addr = {m_addr[19:0], io_out};
          if (io_oe != 4'hF) m_oe_err++;
        end else if (a < 8) begin
          m_mode = {m_mode[3:0], io_out};
          if (io_oe != 4'hF) m_oe_err++;
        end else begin
          if (io_oe != 4'h0) m_oe_err++;
        end
      end
      cyc++;
    end
  end

  always @(negedge sclk) begin
    int k;
    logic [7:0] b;
    if (!cs_n) begin
      k = cyc - base - 12;
      if (k >= 0 && k < 8) begin
        b = fbyte(m_addr + 24'(k / 2));
        io_in <= (k % 2 == 0) ? b[7:4] : b[3:0];
      end
    end
  end

  always @(posedge cs_n) begin
    t_cs_rise = $realtime;
    if (cyc > 0) begin
      m_txn++;
      m_last_cycles = cyc;
      m_last_cmd  = m_expect_cmd ? m_cmd : 8'h00;
      m_last_mode = m_mode;
      if (!m_expect_cmd || m_cmd == 8'hEB) m_cont = (m_mode[7:4] == 4'hA);
      cyc = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(cs_n == 1'b1, "R11 cs_n", 32'(cs_n), 1);
    chk(sclk == 1'b0, "R11 sclk", 32'(sclk), 0);
    chk(io_oe == 4'h0, "R11 io_oe", 32'(io_oe), 0);
    chk(busy == 1'b0 && req_ready == 1'b1, "R11 busy/ready", {busy, req_ready}, 1);
    chk(rsp_valid == 1'b0 && cont_mode == 1'b0, "R11 rsp/cont", {rsp_valid, cont_mode}, 0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    mode_byte = 8'hFF;
    do_read(24'h000100, d);
    chk(d == exp_word(24'h000100), "R5 plain data", d, exp_word(24'h000100));
    chk(m_last_cmd == 8'hEB, "R1 opcode", m_last_cmd, 8'hEB);
    chk(m_last_cycles == 28, "R2 cycle count", m_last_cycles, 28);
    chk(m_oe_err == 0, "R4 lane enables", m_oe_err, 0);
    chk(busy == 1'b0, "R10 busy falls with rsp", busy, 0);
  endtask

  task automatic t_stale_nibble();
    logic [31:0] d;
    mode_byte = 8'hFF;
    do_read(24'hF000A0, d);
    chk(m_last_mode == 8'hFF, "R3 mode byte not address", m_last_mode, 8'hFF);
    chk(cont_mode == 1'b0, "R6 cont stays off", cont_mode, 0);
    chk(d == exp_word(24'hF000A0), "R5 data", d, exp_word(24'hF000A0));
    do_read(24'hF000B0, d);
    chk(m_last_cmd == 8'hEB, "R1 opcode still sent", m_last_cmd, 8'hEB);
    chk(d == exp_word(24'hF000B0), "R5 data", d, exp_word(24'hF000B0));
  endtask

  task automatic t_cont();
    logic [31:0] d;
    mode_byte = 8'hA5;
    do_read(24'h001234, d);
    chk(m_last_mode == 8'hA5, "R3 mode byte", m_last_mode, 8'hA5);
    chk(cont_mode == 1'b1, "R6 cont set", cont_mode, 1);
    chk(d == exp_word(24'h001234), "R5 data", d, exp_word(24'h001234));
    do_read(24'h000040, d);
    chk(m_last_cycles == 20, "R6 opcode omitted", m_last_cycles, 20);
    chk(d == exp_word(24'h000040), "R6 data in cont", d, exp_word(24'h000040));
  endtask

  task automatic t_exit();
    logic [31:0] d;
    @(negedge clk) exit_req = 1'b1;
    @(negedge clk) exit_req = 1'b0;
    do_read(24'h002000, d);
    chk(m_last_cycles == 20, "R7 exit txn no opcode", m_last_cycles, 20);
    chk(m_last_mode == 8'hFF, "R7 exit mode byte", m_last_mode, 8'hFF);
    chk(cont_mode == 1'b0, "R7 cont cleared", cont_mode, 0);
    chk(d == exp_word(24'h002000), "R7 data", d, exp_word(24'h002000));
    mode_byte = 8'hFF;
    do_read(24'h002004, d);
    chk(m_last_cmd == 8'hEB && m_last_cycles == 28, "R7 opcode back", m_last_cycles, 28);
  endtask

  task automatic t_busy_ignore();
    int t0;
    t0 = m_txn;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 24'h000300;
    @(negedge clk);
    req_addr  = 24'h000777;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 && busy == 1'b1, "R10 not ready while busy", {busy, req_ready}, 2);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == exp_word(24'h000300), "R10 first request kept", rsp_data, exp_word(24'h000300));
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && m_txn == t0 + 1, "R10 busy request ignored", m_txn - t0, 1);
  endtask

  task automatic t_divider(input logic [7:0] dv);
    logic [31:0] d;
    int per;
    clk_div = dv;
    do_read(24'h000510, d);
    per = int'((t_rise_last - t_rise_prev) / 5.0);
    chk(per == 2 * (int'(dv) + 1), "R8 sclk period", per, 2 * (int'(dv) + 1));
    chk(d == exp_word(24'h000510), "R8 data at divider", d, exp_word(24'h000510));
  endtask

  task automatic t_gap();
    logic [31:0] d;
    int g;
    clk_div = 8'd3;
    do_read(24'h000600, d);
    do_read(24'h000604, d);
    g = int'(m_gap / 5.0);
    chk(g >= 8, "R9 cs gap", g, 8);
    chk(d == exp_word(24'h000604), "R9 back-to-back data", d, exp_word(24'h000604));
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    clk_div = 8'd1;
    do_read(24'h00FFFE, d);
    chk(d == exp_word(24'h00FFFE), "R5 byte order across boundary", d, exp_word(24'h00FFFE));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_plain();
    t_stale_nibble();
    t_cont();
    t_exit();
    t_busy_ignore();
    t_divider(8'd0);
    t_divider(8'd3);
    t_gap();
    t_wrap();
    chk(m_oe_err == 0, "R4 lanes released in dummy/data", m_oe_err, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule